// File: doc/BRIEF.md
# Two-wire Serial Memory Slave Front End

This block is the bus-side protocol engine of a serial memory that sits on a two-wire bus. It oversamples the clock and data lines with the system clock and recognises start and stop conditions. It then shifts in the device address byte and compares it with a fixed `1010` prefix and three board-strapped select pins. On a match it pulls the data line low to acknowledge. For a write selection it then collects two word-address bytes, followed by any number of data bytes. It hands each of these bytes to a byte-level back end.

The back-end handoff is valid/ready. `byte_valid_o` rises three clocks after the SCL rising edge that carries the eighth bit. It stays high with `byte_data_o` and `byte_kind_o` stable until `byte_ready_i` is seen high, or until the SCL falling edge that ends the eighth bit. At that edge a byte that was taken is acknowledged. A byte that was not taken is withdrawn and refused with a not-acknowledge, and the slave drops to standby, because the bus cannot wait. When a read is selected the block only records the operation on `rd_mode_o` and releases the bus. While `busy_i` is high (the internal write cycle of the memory), the block ignores the bus entirely.

Top module: `eeprom_bus_front`

## Requirements
- R1: A start condition (SDA falling while SCL is high) begins reception of a device address byte from any state, including in the middle of a transfer (repeated start).
- R2: A device address byte is matched when its bits 7..4 are `1010` and bits 3..1 equal `strap_i[2:0]`. On a match `sda_pull_o` is high while SCL is high during the ninth clock.
- R3: A device address byte that does not match gets no acknowledge. Later bytes get no acknowledge and no `byte_valid_o` until the next start.
- R4: Bit 0 of a matched device address byte sets `rd_mode_o` (1 = read, 0 = write). After a read selection the bus is released and no byte is presented or acknowledged.
- R5: After a write selection the next two bytes are word-address bytes. Each is acknowledged and presented with `byte_kind_o` 0 (high byte) and then 1 (low byte).
- R6: Every later byte until a stop or start is presented with `byte_kind_o` 2 and acknowledged.
- R7: `byte_valid_o` holds with stable data until `byte_ready_i` or the SCL fall ending the eighth bit. A byte not taken by then gets no acknowledge, and the slave goes to standby.
- R8: While `busy_i` is high, start conditions and all bits are ignored, `sda_pull_o` is low and `byte_valid_o` is low.
- R9: A stop condition, or a start in the middle of a byte, aborts the transfer and clears the bit count, so a following complete address is matched normally.
- R10: `sda_pull_o` is asserted only while SCL is low. It is released at the SCL fall that ends the ninth clock.
- R11: After reset `sda_pull_o`, `byte_valid_o` and `rd_mode_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Board-strapped device select bits |
| busy_i | input | 1 | Internal write cycle running; bus ignored |
| byte_ready_i | input | 1 | Back end accepts the presented byte |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases |
| byte_valid_o | output | 1 | Received byte is presented |
| byte_data_o | output | 8 | Received byte, MSB first on the bus |
| byte_kind_o | output | 2 | 0 word address high, 1 word address low, 2 data |
| rd_mode_o | output | 1 | Operation bit of the last matched address |

## Verification
Every pin change passes two synchronizer flops and an edge register. The acknowledge therefore appears three clocks after the SCL fall ending the eighth bit, and it is released three clocks after the SCL fall ending the ninth. `byte_valid_o` rises three clocks after the eighth SCL rise. The bench drives each SCL quarter-phase as six clocks and samples the acknowledge in the middle of the ninth clock's high phase. It checks the release one quarter-phase after the ninth fall, and collects handed-off bytes on falling clock edges, so every check lands well after the result settles.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_BITS   = 8;
  localparam int CNT_W       = $clog2(BYTE_BITS);
  localparam int STRAP_W     = 3;
  localparam int PREFIX_W    = 4;
  localparam logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010;
  localparam int WADDR_BYTES = 2;
  localparam int WA_W        = (WADDR_BYTES > 1) ? $clog2(WADDR_BYTES) : 1;
  localparam int KIND_W      = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK_WAIT, S_ACK_HOLD, S_PARK
  } fsm_t;

  typedef enum logic [1:0] {
    ST_DEV, ST_WADDR, ST_DATA, ST_RD
  } stage_t;

  typedef enum logic [KIND_W-1:0] {
    K_ADDR_HI = 2'd0, K_ADDR_LO = 2'd1, K_DATA = 2'd2
  } kind_t;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/twm_cond_detect.sv
module twm_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  // Conditions need SCL high on both samples; data edges otherwise
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
endmodule

// File: rtl/twm_shifter.sv
module twm_shifter
  import twm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 shift_en,
  input  logic                 bit_in,
  output logic [BYTE_BITS-1:0] byte_next,
  output logic                 last_bit
);
  logic [BYTE_BITS-1:0] sreg;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (clear) begin
      cnt  <= '0;
    end else if (shift_en) begin
      sreg <= byte_next;
      cnt  <= last_bit ? '0 : cnt + 1'b1;
    end
  end

  assign byte_next = {sreg[BYTE_BITS-2:0], bit_in};
  assign last_bit  = (cnt == CNT_W'(BYTE_BITS - 1));
endmodule

// File: rtl/eeprom_bus_front.sv
module eeprom_bus_front
  import twm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic                 busy_i,
  input  logic                 byte_ready_i,
  output logic                 sda_pull_o,
  output logic                 byte_valid_o,
  output logic [BYTE_BITS-1:0] byte_data_o,
  output logic [KIND_W-1:0]    byte_kind_o,
  output logic                 rd_mode_o
);
  localparam int PFX_LSB = BYTE_BITS - PREFIX_W;

  logic [1:0] pins_s;
  logic scl_s, sda_s;
  logic start_p, stop_p, scl_rise, scl_fall;
  logic shift_clear, shift_en, last_bit;
  logic [BYTE_BITS-1:0] byte_next;
  logic dev_match;

  fsm_t   state;
  stage_t stage;
  kind_t  kind_q, cur_kind;
  logic [WA_W-1:0] wa_idx;
  logic oe_q, valid_q, taken_q, rd_q;
  logic [BYTE_BITS-1:0] data_q;

  twm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  twm_cond_detect u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  assign shift_clear = busy_i | start_p | stop_p | (state != S_RX);
  assign shift_en    = (state == S_RX) & scl_rise;

  twm_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(shift_clear), .shift_en(shift_en),
    .bit_in(sda_s), .byte_next(byte_next), .last_bit(last_bit)
  );

  assign dev_match = (byte_next[BYTE_BITS-1:PFX_LSB] == DEV_PREFIX) &&
                     (byte_next[PFX_LSB-1:1] == strap_i);

  always_comb begin
    if (stage == ST_DATA)  cur_kind = K_DATA;
    else if (wa_idx == '0) cur_kind = K_ADDR_HI;
    else                   cur_kind = K_ADDR_LO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stage   <= ST_DEV;
      wa_idx  <= '0;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      taken_q <= 1'b0;
      rd_q    <= 1'b0;
      data_q  <= '0;
      kind_q  <= K_ADDR_HI;
    end else if (busy_i) begin
      state   <= S_IDLE;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else if (start_p) begin
      state   <= S_RX;
      stage   <= ST_DEV;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else if (stop_p) begin
      state   <= S_IDLE;
      oe_q    <= 1'b0;
      valid_q <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      unique case (state)
        S_RX: begin
          if (scl_rise && last_bit) begin
            if (stage == ST_DEV) begin
              if (dev_match) begin
                state   <= S_ACK_WAIT;
                taken_q <= 1'b1;
                rd_q    <= byte_next[0];
              end else begin
                state   <= S_IDLE;
              end
            end else begin
              state   <= S_ACK_WAIT;
              valid_q <= 1'b1;
              taken_q <= 1'b0;
              data_q  <= byte_next;
              kind_q  <= cur_kind;
            end
          end
        end
        S_ACK_WAIT: begin
          if (valid_q && byte_ready_i) begin
            valid_q <= 1'b0;
            taken_q <= 1'b1;
          end
          if (scl_fall) begin
            valid_q <= 1'b0;
            if (taken_q || (valid_q && byte_ready_i)) begin
              oe_q  <= 1'b1;
              state <= S_ACK_HOLD;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ACK_HOLD: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            taken_q <= 1'b0;
            state   <= S_RX;
            unique case (stage)
              ST_DEV: begin
                if (rd_q) begin
                  stage <= ST_RD;
                  state <= S_PARK;
                end else begin
                  stage  <= ST_WADDR;
                  wa_idx <= '0;
                end
              end
              ST_WADDR: begin
                if (wa_idx == WA_W'(WADDR_BYTES - 1)) stage <= ST_DATA;
                else wa_idx <= wa_idx + 1'b1;
              end
              default: ;
            endcase
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o   = oe_q;
  assign byte_valid_o = valid_q;
  assign byte_data_o  = data_q;
  assign byte_kind_o  = kind_q;
  assign rd_mode_o    = rd_q;

  // R10
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (!sda_pull_o && !byte_valid_o));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i && !scl_fall && !start_p && !stop_p && !busy_i)
    |=> (byte_valid_o && $stable(byte_data_o) && $stable(byte_kind_o)));

  // R3
  standby_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!sda_pull_o && !byte_valid_o));

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !busy_i) |=> (!sda_pull_o && !byte_valid_o));
endmodule

// File: tb/tb_eeprom_bus_front.sv
module tb_eeprom_bus_front;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b011;
  logic busy = 1'b0, ready = 1'b1;
  logic sda_pull, bvalid, rd_mode;
  logic [7:0] bdata;
  logic [1:0] bkind;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, fails = 0;
  bit done = 0;
  int cap_n = 0;
  logic [7:0] cap_data [64];
  logic [1:0] cap_kind [64];
  bit vseen = 0;
  int rise_viol = 0;
  logic prev_pull = 1'b0;

  always #5 clk = ~clk;

  eeprom_bus_front dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .busy_i(busy), .byte_ready_i(ready), .sda_pull_o(sda_pull),
    .byte_valid_o(bvalid), .byte_data_o(bdata), .byte_kind_o(bkind), .rd_mode_o(rd_mode)
  );

  always @(negedge clk) begin
    if (bvalid) vseen = 1;
    if (bvalid && ready && cap_n < 64) begin
      cap_data[cap_n] = bdata;
      cap_kind[cap_n] = bkind;
      cap_n++;
    end
    if (sda_pull && !prev_pull && scl_m) rise_viol++;
    prev_pull = sda_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; waitc(Q);
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl_m = 1'b0; waitc(Q);
      sda_m = b[i]; waitc(Q);
      scl_m = 1'b1; waitc(2*Q);
    end
    scl_m = 1'b0;
  endtask

  // Full byte plus ninth clock; ack sampled mid-high, release checked after fall
  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    waitc(Q);
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    ack = sda_pull; waitc(Q);
    scl_m = 1'b0; waitc(Q);
    if (ack) chk(!sda_pull, "R10 release after ninth clock", sda_pull, 0);
  endtask

  task automatic t_reset();
    chk(sda_pull == 0, "R11 pull at reset", sda_pull, 0);
    chk(bvalid == 0, "R11 valid at reset", bvalid, 0);
    chk(rd_mode == 0, "R11 rd_mode at reset", rd_mode, 0);
  endtask

  task automatic t_write();
    logic a; int base;
    logic [7:0] pl [4] = '{8'h1F, 8'hA5, 8'h3C, 8'hC3};
    logic [1:0] kd [4] = '{2'd0, 2'd1, 2'd2, 2'd2};
    base = cap_n;
    bus_start();
    send_byte(8'hA6, a); chk(a, "R2 write address ack", a, 1);
    chk(rd_mode == 0, "R4 write bit decode", rd_mode, 0);
    for (int i = 0; i < 4; i++) begin
      send_byte(pl[i], a);
      chk(a, (i < 2) ? "R5 word address ack" : "R6 data ack", a, 1);
    end
    bus_stop();
    chk(cap_n == base + 4, "R5 byte count", cap_n - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk(cap_data[base+i] == pl[i], (i < 2) ? "R5 addr data" : "R6 data value",
          cap_data[base+i], pl[i]);
      chk(cap_kind[base+i] == kd[i], (i < 2) ? "R5 addr kind" : "R6 data kind",
          cap_kind[base+i], kd[i]);
    end
  endtask

  task automatic t_mismatch();
    logic a; int base;
    base = cap_n;
    bus_start();
    send_byte(8'hA4, a); chk(!a, "R3 strap mismatch nack", a, 0);
    send_byte(8'h55, a); chk(!a, "R3 standby after mismatch", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hE6, a); chk(!a, "R2 prefix mismatch nack", a, 0);
    bus_stop();
    chk(cap_n == base, "R3 no bytes presented", cap_n - base, 0);
  endtask

  task automatic t_strap();
    logic a;
    strap = 3'b101;
    bus_start();
    send_byte(8'hAA, a); chk(a, "R2 other strap ack", a, 1);
    bus_stop();
    strap = 3'b011;
  endtask

  task automatic t_read();
    logic a; int base;
    base = cap_n;
    bus_start();
    send_byte(8'hA7, a); chk(a, "R4 read address ack", a, 1);
    chk(rd_mode == 1, "R4 read bit decode", rd_mode, 1);
    send_byte(8'h12, a); chk(!a, "R4 bus released on read", a, 0);
    bus_stop();
    chk(cap_n == base, "R4 no byte on read", cap_n - base, 0);
  endtask

  task automatic t_backpressure();
    logic a; int base;
    base = cap_n;
    bus_start();
    send_byte(8'hA6, a); chk(a, "R7 address ack", a, 1);
    ready = 1'b0; vseen = 0;
    send_byte(8'h40, a); chk(!a, "R7 refused byte nack", a, 0);
    chk(vseen, "R7 valid was offered", vseen, 1);
    ready = 1'b1;
    send_byte(8'h41, a); chk(!a, "R7 standby after refusal", a, 0);
    bus_stop();
    chk(cap_n == base, "R7 nothing accepted", cap_n - base, 0);
  endtask

  task automatic t_busy();
    logic a; int base;
    base = cap_n;
    busy = 1'b1; vseen = 0;
    bus_start();
    send_byte(8'hA6, a); chk(!a, "R8 no ack while busy", a, 0);
    busy = 1'b0;
    send_byte(8'hA6, a); chk(!a, "R8 start ignored while busy", a, 0);
    bus_stop();
    chk(!vseen && cap_n == base, "R8 no byte while busy", cap_n - base, 0);
  endtask

  task automatic t_abort();
    logic a; int base;
    bus_start();
    send_bits(8'hA6, 4);
    bus_stop();
    bus_start();
    send_byte(8'hA6, a); chk(a, "R9 address after stop abort", a, 1);
    send_bits(8'hFF, 3);
    bus_start();
    send_byte(8'hA6, a); chk(a, "R1 repeated start mid byte", a, 1);
    base = cap_n;
    send_byte(8'h01, a); chk(a, "R9 word address after restart", a, 1);
    bus_stop();
    chk(cap_n == base + 1 && cap_kind[base] == 2'd0, "R9 kind restarted at high",
        cap_kind[base], 0);
  endtask

  initial begin
    waitc(4);
    t_reset();
    rst_n = 1'b1;
    waitc(10);
    t_write();
    t_mismatch();
    t_strap();
    t_read();
    t_backpressure();
    t_busy();
    t_abort();
    chk(rise_viol == 0, "R10 pull asserted only with SCL low", rise_viol, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule